// File: doc/BRIEF.md
# Ring Controller Start-Up and Suspend Sequencer

This block is the control core of a ring-based network controller. It accepts host commands (initialize, start, stop, done-acknowledge and a level-sensitive suspend request). It brings the controller up along one of two paths. On the first path it fetches a parameter block from memory through a word-read port and copies the relevant words into the mode, ring-base and ring-length registers. On the second path the host writes those registers directly and issues start with no memory traffic. When a fetch completes, a done flag is raised, and the interrupt line is raised only if interrupts are enabled.

Once running, the block keeps an on/off flag for the transmit section and for the receive section. It also keeps one working descriptor pointer per ring, which advances by one entry on request and wraps at the ring length. A suspend request is served by draining transmit first and receive second, through request/acknowledge pairs. Only then is the suspend status raised. Dropping the request resumes operation at the same ring positions.

The memory port follows valid/ready rules. A read request stays valid with a stable address until `rd_req_ready` is sampled high. Only one read is outstanding at a time. The response is taken in the cycle where both `rd_rsp_valid` and `rd_rsp_ready` are high. The responder may stall either side for any number of cycles.

Top module: `nic_init_seq`

## Requirements
- R1: After reset, both sections are off, the done, interrupt and suspend status outputs are 0, no read is requested, and all configuration registers and ring pointers read 0.
- R2: An initialize command issues exactly 12 word reads at byte addresses {blk_addr_hi, blk_addr_lo} + 2k for k = 0..11, in increasing order. A request holds its address until accepted, and the next request is not issued before the previous response arrives.
- R3: Fetched word k is loaded as follows. Word 0 goes to the mode register. Words 1 and 2 go to the transmit ring base (word 1 is bits 15:0, the low 8 bits of word 2 are bits 23:16). Word 3 bits 7:0 give the transmit ring length. Words 4, 5 and 6 fill the receive base and length in the same layout. Words 7 to 11 are read and discarded.
- R4: The done flag is set in the cycle after the last word is accepted. The interrupt output is set at the same time only when int_en is 1. A done-acknowledge command clears both.
- R5: A start command given together with initialize, or during the fetch, enables the sections when the fetch completes. A start command given while idle uses the directly loaded registers and issues no read. The sections are off while a fetch runs.
- R6: A direct write with index k (same index layout as R3) loads that register. Direct writes are ignored while a fetch runs, and a later initialize overwrites directly written values.
- R7: On start, tx_on becomes the inverse of mode bit 0 and rx_on becomes the inverse of mode bit 1.
- R8: A transmit or receive error pulse turns that section off. It stays off until the next start or initialize.
- R9: Every start, including a restart after stop, reloads both working pointers to their ring bases. An advance pulse on a running section that is on moves its pointer by 8 bytes and wraps to the base after `len` entries, with length 0 treated as 1. Advance pulses on a section that is off have no effect.
- R10: A suspend request first drains transmit (skipped if transmit is off), then drains receive (skipped if receive is off). Suspend status rises only after both drains are acknowledged.
- R11: Releasing the suspend request returns to running with both pointers and both section flags unchanged.
- R12: Stop overrides every other command. In the next cycle the block is idle, both sections are off, any fetch is aborted, and the done, interrupt and suspend status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_init | input | 1 | Initialize command pulse |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_done_clr | input | 1 | Clears done flag and interrupt |
| spnd_req | input | 1 | Suspend request level |
| int_en | input | 1 | Interrupt enable |
| blk_addr_lo | input | 16 | Parameter block address bits 15:0 |
| blk_addr_hi | input | 8 | Parameter block address bits 23:16 |
| dw_en | input | 1 | Direct register write strobe |
| dw_idx | input | 4 | Direct write register index |
| dw_data | input | 16 | Direct write data |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request ready |
| rd_req_addr | output | 24 | Memory read byte address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 16 | Read response word |
| rd_rsp_ready | output | 1 | Read response ready |
| tx_err | input | 1 | Transmit error pulse |
| rx_err | input | 1 | Receive error pulse |
| tx_adv | input | 1 | Advance transmit ring pointer |
| rx_adv | input | 1 | Advance receive ring pointer |
| tx_drain_req | output | 1 | Request transmit section drain |
| tx_drain_ack | input | 1 | Transmit drain finished |
| rx_drain_req | output | 1 | Request receive section drain |
| rx_drain_ack | input | 1 | Receive drain finished |
| mode | output | 16 | Mode register |
| tx_base | output | 24 | Transmit ring base |
| rx_base | output | 24 | Receive ring base |
| tx_len | output | 8 | Transmit ring length |
| rx_len | output | 8 | Receive ring length |
| tx_ptr | output | 24 | Transmit working pointer |
| rx_ptr | output | 24 | Receive working pointer |
| init_done | output | 1 | Fetch completion flag |
| irq | output | 1 | Interrupt |
| tx_on | output | 1 | Transmit section running |
| rx_on | output | 1 | Receive section running |
| spnd_stat | output | 1 | Suspend entered |
| fetch_busy | output | 1 | Parameter fetch in progress |

## Verification
The hardest cases to reach from the ports are those that depend on where a fetch stands when something else arrives. One is a direct write that lands after its own word has already been fetched. The other is a stop issued while a read is outstanding. The bench's memory responder stalls request and response by a configurable amount and counts accepted reads. The stimulus waits on that count, so the conflicting write or stop is injected mid-fetch at a known point. A sweep over stall depth, interrupt enable and start timing covers both start paths.

// File: rtl/nic_init_pkg.sv
package nic_init_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_RUN, ST_DRN_TX, ST_DRN_RX, ST_SUSP
  } seq_st_e;

  // register index layout shared by fetched words and direct writes
  localparam int unsigned IDX_MODE  = 0;
  localparam int unsigned IDX_RING0 = 1;  // lo, hi, len for ring r at IDX_RING0 + 3r
  localparam int unsigned RING_STRIDE = 3;

  localparam int unsigned MODE_TXOFF_BIT = 0;
  localparam int unsigned MODE_RXOFF_BIT = 1;
endpackage

// File: rtl/nic_blk_fetch.sv
module nic_blk_fetch #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned BLK_WORDS = 12,
  localparam int unsigned SEL_W    = $clog2(BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              abort,
  input  logic [ADDR_W-1:0] base,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              rd_rsp_ready,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data,
  output logic              last,
  output logic              busy
);
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(BLK_WORDS - 1);

  logic              busy_q, wait_q;
  logic [SEL_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wait_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      wait_q <= 1'b0;
      idx_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      wait_q <= 1'b0;
      idx_q  <= '0;
      base_q <= base;
    end else if (busy_q) begin
      if (!wait_q) begin
        if (rd_req_ready) wait_q <= 1'b1;
      end else if (rd_rsp_valid) begin
        wait_q <= 1'b0;
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // byte address of the current 16-bit word
  assign rd_req_addr  = base_q + (ADDR_W'(idx_q) << 1);
  assign rd_req_valid = busy_q && !wait_q;
  assign rd_rsp_ready = busy_q && wait_q;
  assign wr_en        = busy_q && wait_q && rd_rsp_valid && !abort;
  assign wr_idx       = idx_q;
  assign wr_data      = rd_rsp_data;
  assign last         = wr_en && (idx_q == LAST_IDX);
  assign busy         = busy_q;
endmodule

// File: rtl/nic_cfg_bank.sv
module nic_cfg_bank #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned RINGS  = 2,
  localparam int unsigned HI_W  = ADDR_W - WORD_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_idx,
  input  logic [WORD_W-1:0]            wr_data,
  output logic [WORD_W-1:0]            mode,
  output logic [RINGS-1:0][ADDR_W-1:0] ring_base,
  output logic [RINGS-1:0][LEN_W-1:0]  ring_len
);
  import nic_init_pkg::*;

  logic [WORD_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (wr_en && wr_idx == SEL_W'(IDX_MODE)) mode_q <= wr_data;
  end
  assign mode = mode_q;

  for (genvar r = 0; r < RINGS; r++) begin : g_ring_regs
    localparam int unsigned LO = IDX_RING0 + RING_STRIDE * r;
    logic [WORD_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic [LEN_W-1:0]  len_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        len_q <= '0;
      end else if (wr_en) begin
        if (wr_idx == SEL_W'(LO))     lo_q  <= wr_data;
        if (wr_idx == SEL_W'(LO + 1)) hi_q  <= wr_data[HI_W-1:0];
        if (wr_idx == SEL_W'(LO + 2)) len_q <= wr_data[LEN_W-1:0];
      end
    end
    assign ring_base[r] = {hi_q, lo_q};
    assign ring_len[r]  = len_q;
  end
endmodule

// File: rtl/nic_ring_ptr.sv
module nic_ring_ptr #(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned ENTRY_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ENTRY_BYTES);

  logic [ADDR_W-1:0] ptr_q;
  logic [LEN_W-1:0]  idx_q;
  logic              at_end;

  assign at_end = (len <= LEN_W'(1)) || (idx_q >= len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      ptr_q <= base;
      idx_q <= '0;
    end else if (adv) begin
      if (at_end) begin
        ptr_q <= base;
        idx_q <= '0;
      end else begin
        ptr_q <= ptr_q + STEP;
        idx_q <= idx_q + 1'b1;
      end
    end
  end
  assign ptr = ptr_q;
endmodule

// File: rtl/nic_init_seq.sv
module nic_init_seq #(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned BLK_WORDS   = 12,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned ENTRY_BYTES = 8,
  localparam int unsigned SEL_W      = $clog2(BLK_WORDS),
  localparam int unsigned HI_W       = ADDR_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_init,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cmd_done_clr,
  input  logic              spnd_req,
  input  logic              int_en,
  input  logic [WORD_W-1:0] blk_addr_lo,
  input  logic [HI_W-1:0]   blk_addr_hi,
  input  logic              dw_en,
  input  logic [SEL_W-1:0]  dw_idx,
  input  logic [WORD_W-1:0] dw_data,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              rd_rsp_ready,
  input  logic              tx_err,
  input  logic              rx_err,
  input  logic              tx_adv,
  input  logic              rx_adv,
  output logic              tx_drain_req,
  input  logic              tx_drain_ack,
  output logic              rx_drain_req,
  input  logic              rx_drain_ack,
  output logic [WORD_W-1:0] mode,
  output logic [ADDR_W-1:0] tx_base,
  output logic [ADDR_W-1:0] rx_base,
  output logic [LEN_W-1:0]  tx_len,
  output logic [LEN_W-1:0]  rx_len,
  output logic [ADDR_W-1:0] tx_ptr,
  output logic [ADDR_W-1:0] rx_ptr,
  output logic              init_done,
  output logic              irq,
  output logic              tx_on,
  output logic              rx_on,
  output logic              spnd_stat,
  output logic              fetch_busy
);
  import nic_init_pkg::*;

  localparam int unsigned RINGS = 2;

  seq_st_e st_q, st_d;
  logic pend_q, pend_d, done_q, done_d, irq_q, irq_d;
  logic txon_q, txon_d, rxon_q, rxon_d;
  logic ptr_load, fetch_go;

  logic             f_wr_en, f_last;
  logic [SEL_W-1:0] f_wr_idx;
  logic [WORD_W-1:0] f_wr_data;
  logic             b_wr_en;
  logic [SEL_W-1:0] b_wr_idx;
  logic [WORD_W-1:0] b_wr_data;

  logic [RINGS-1:0][ADDR_W-1:0] ring_base, ring_ptr;
  logic [RINGS-1:0][LEN_W-1:0]  ring_len;
  logic [RINGS-1:0]             ring_adv;

  // ---------------- parameter block fetch ----------------
  assign fetch_go = !cmd_stop && cmd_init && (st_q == ST_IDLE || st_q == ST_RUN);

  nic_blk_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)) u_fetch (
    .clk, .rst_n,
    .go(fetch_go), .abort(cmd_stop), .base({blk_addr_hi, blk_addr_lo}),
    .rd_req_valid, .rd_req_ready, .rd_req_addr,
    .rd_rsp_valid, .rd_rsp_data, .rd_rsp_ready,
    .wr_en(f_wr_en), .wr_idx(f_wr_idx), .wr_data(f_wr_data),
    .last(f_last), .busy(fetch_busy)
  );

  // fetched words own the bank while a fetch runs; direct writes are dropped then
  assign b_wr_en   = f_wr_en || (dw_en && !fetch_busy && st_q != ST_FETCH);
  assign b_wr_idx  = f_wr_en ? f_wr_idx  : dw_idx;
  assign b_wr_data = f_wr_en ? f_wr_data : dw_data;

  nic_cfg_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LEN_W(LEN_W),
                 .SEL_W(SEL_W), .RINGS(RINGS)) u_bank (
    .clk, .rst_n,
    .wr_en(b_wr_en), .wr_idx(b_wr_idx), .wr_data(b_wr_data),
    .mode, .ring_base, .ring_len
  );

  // ---------------- working pointers ----------------
  assign ring_adv[0] = tx_adv && st_q == ST_RUN && txon_q;
  assign ring_adv[1] = rx_adv && st_q == ST_RUN && rxon_q;

  for (genvar r = 0; r < RINGS; r++) begin : g_ring
    nic_ring_ptr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ENTRY_BYTES(ENTRY_BYTES)) u_ptr (
      .clk, .rst_n,
      .load(ptr_load), .adv(ring_adv[r]),
      .base(ring_base[r]), .len(ring_len[r]), .ptr(ring_ptr[r])
    );
  end

  // ---------------- command sequencer ----------------
  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    done_d   = done_q;
    irq_d    = irq_q;
    txon_d   = txon_q;
    rxon_d   = rxon_q;
    ptr_load = 1'b0;

    if (cmd_done_clr) begin
      done_d = 1'b0;
      irq_d  = 1'b0;
    end

    if (cmd_stop) begin
      st_d   = ST_IDLE;
      pend_d = 1'b0;
      done_d = 1'b0;
      irq_d  = 1'b0;
      txon_d = 1'b0;
      rxon_d = 1'b0;
    end else begin
      if (st_q == ST_RUN || st_q == ST_DRN_TX || st_q == ST_DRN_RX) begin
        if (tx_err) txon_d = 1'b0;
        if (rx_err) rxon_d = 1'b0;
      end
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_init) begin
            st_d   = ST_FETCH;
            pend_d = cmd_start;
          end else if (cmd_start) begin
            st_d     = ST_RUN;
            ptr_load = 1'b1;
            txon_d   = !mode[MODE_TXOFF_BIT];
            rxon_d   = !mode[MODE_RXOFF_BIT];
          end
        end
        ST_FETCH: begin
          if (cmd_start) pend_d = 1'b1;
          if (f_last) begin
            done_d = 1'b1;
            irq_d  = irq_q || int_en;
            pend_d = 1'b0;
            if (pend_q || cmd_start) begin
              st_d     = ST_RUN;
              ptr_load = 1'b1;
              txon_d   = !mode[MODE_TXOFF_BIT];
              rxon_d   = !mode[MODE_RXOFF_BIT];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_RUN: begin
          if (cmd_init) begin
            st_d   = ST_FETCH;
            pend_d = cmd_start;
            txon_d = 1'b0;
            rxon_d = 1'b0;
          end else if (cmd_start) begin
            ptr_load = 1'b1;
            txon_d   = !mode[MODE_TXOFF_BIT];
            rxon_d   = !mode[MODE_RXOFF_BIT];
          end else if (spnd_req) begin
            if (txon_d)      st_d = ST_DRN_TX;
            else if (rxon_d) st_d = ST_DRN_RX;
            else             st_d = ST_SUSP;
          end
        end
        ST_DRN_TX: begin
          if (tx_drain_ack) st_d = rxon_d ? ST_DRN_RX : ST_SUSP;
        end
        ST_DRN_RX: begin
          if (rx_drain_ack) st_d = ST_SUSP;
        end
        ST_SUSP: begin
          if (!spnd_req) st_d = ST_RUN;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      txon_q <= 1'b0;
      rxon_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      done_q <= done_d;
      irq_q  <= irq_d;
      txon_q <= txon_d;
      rxon_q <= rxon_d;
    end
  end

  assign tx_drain_req = (st_q == ST_DRN_TX);
  assign rx_drain_req = (st_q == ST_DRN_RX);
  assign spnd_stat    = (st_q == ST_SUSP);
  assign init_done    = done_q;
  assign irq          = irq_q;
  assign tx_on        = txon_q;
  assign rx_on        = rxon_q;
  assign tx_base      = ring_base[0];
  assign rx_base      = ring_base[1];
  assign tx_len       = ring_len[0];
  assign rx_len       = ring_len[1];
  assign tx_ptr       = ring_ptr[0];
  assign rx_ptr       = ring_ptr[1];
endmodule

// File: rtl/nic_init_seq_chk.sv
module nic_init_seq_chk #(
  parameter int unsigned ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_stop,
  input logic              int_en,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_ready,
  input logic              fetch_busy,
  input logic              init_done,
  input logic              irq,
  input logic              tx_on,
  input logic              rx_on,
  input logic              spnd_stat,
  input logic              tx_drain_req,
  input logic              rx_drain_req
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready && !cmd_stop) |=> (rd_req_valid && $stable(rd_req_addr)));

  p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_ready |-> !rd_req_valid);

  p_port_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_busy |-> (!rd_req_valid && !rd_rsp_ready));

  p_off_in_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_busy |-> (!tx_on && !rx_on));

  p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(int_en));

  p_done_ends_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(fetch_busy));

  p_drain_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_drain_req && rx_drain_req));

  p_rx_after_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_drain_req) |-> ($past(tx_drain_req) || !tx_on));

  p_stop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> (!tx_on && !rx_on && !fetch_busy && !spnd_stat && !init_done && !irq));
endmodule

bind nic_init_seq nic_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_nic_init_seq.sv
module test_nic_init_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        rst_n, cmd_init, cmd_start, cmd_stop, cmd_done_clr, spnd_req, int_en;
  logic [15:0] blk_addr_lo;
  logic [7:0]  blk_addr_hi;
  logic        dw_en;
  logic [3:0]  dw_idx;
  logic [15:0] dw_data;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [23:0] rd_req_addr;
  logic [15:0] rd_rsp_data;
  logic        tx_err, rx_err, tx_adv, rx_adv;
  logic        tx_drain_req, tx_drain_ack, rx_drain_req, rx_drain_ack;
  logic [15:0] mode;
  logic [23:0] tx_base, rx_base, tx_ptr, rx_ptr;
  logic [7:0]  tx_len, rx_len;
  logic        init_done, irq, tx_on, rx_on, spnd_stat, fetch_busy;

  nic_init_seq i_nic_init_seq (.*);

  int n_chk = 0, n_bad = 0;
  bit reported = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // ---------------- memory responder ----------------
  logic [15:0] blk [12];
  int          lat = 0;
  logic [23:0] cur_base;
  int rd_cnt = 0, addr_err = 0;
  int cyc = 0, pdly = 0, pidx = 0;
  bit pending = 0, rsp_out = 0, req_take = 0;
  logic [23:0] take_addr;

  initial begin : mem_model
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!fetch_busy) begin
        pending = 0; rsp_out = 0; req_take = 0;
        rd_rsp_valid = 1'b0;
        rd_req_ready = 1'b0;
      end else begin
        if (rsp_out) begin rsp_out = 0; rd_rsp_valid = 1'b0; end
        if (req_take) begin
          req_take = 0;
          rd_cnt++;
          if (take_addr !== 24'(cur_base + 2 * (rd_cnt - 1))) addr_err++;
          pidx = int'((take_addr - cur_base) >> 1);
          pending = 1;
          pdly = lat;
        end
        if (pending) begin
          if (pdly == 0) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = (pidx < 12) ? blk[pidx] : 16'hxxxx;
            pending = 0;
            rsp_out = 1;
          end else pdly--;
        end
        rd_req_ready = ((cyc % (lat + 1)) == 0);
        if (rd_req_valid && rd_req_ready) begin
          req_take  = 1;
          take_addr = rd_req_addr;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(); @(negedge clk); endtask

  task automatic dwrite(int idx, logic [15:0] d);
    dw_en = 1'b1; dw_idx = 4'(idx); dw_data = d;
    tick();
    dw_en = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(); s = 1'b0;
  endtask

  task automatic stop_all();
    pulse(cmd_stop);
    tick();
  endtask

  task automatic load_direct(logic [15:0] m, logic [23:0] tb, logic [7:0] tl,
                             logic [23:0] rb, logic [7:0] rl);
    dwrite(0, m);
    dwrite(1, tb[15:0]); dwrite(2, {8'h00, tb[23:16]}); dwrite(3, {8'h00, tl});
    dwrite(4, rb[15:0]); dwrite(5, {8'h00, rb[23:16]}); dwrite(6, {8'h00, rl});
  endtask

  initial begin : main
    rst_n = 1'b0; cmd_init = 0; cmd_start = 0; cmd_stop = 0; cmd_done_clr = 0;
    spnd_req = 0; int_en = 0; blk_addr_lo = '0; blk_addr_hi = '0;
    dw_en = 0; dw_idx = '0; dw_data = '0;
    tx_err = 0; rx_err = 0; tx_adv = 0; rx_adv = 0; tx_drain_ack = 0; rx_drain_ack = 0;
    cur_base = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 tx_on", tx_on, 0);       chk("R1 rx_on", rx_on, 0);
    chk("R1 done", init_done, 0);    chk("R1 irq", irq, 0);
    chk("R1 req", rd_req_valid, 0);  chk("R1 spnd", spnd_stat, 0);
    chk("R1 mode", mode, 0);         chk("R1 tx_base", tx_base, 0);
    chk("R1 rx_ptr", rx_ptr, 0);

    // R5/R7 direct start, all mode combinations
    for (int m = 0; m < 4; m++) begin
      logic [23:0] tb, rb;
      tb = 24'h120000 + 24'(m * 24'h100);
      rb = 24'h340000 + 24'(m * 24'h200);
      load_direct(16'(m), tb, 8'd4, rb, 8'd5);
      rd_cnt = 0;
      pulse(cmd_start);
      chk("R7 tx_on", tx_on, 32'(!m[0]));
      chk("R7 rx_on", rx_on, 32'(!m[1]));
      chk("R9 tx_ptr load", tx_ptr, tb);
      chk("R9 rx_ptr load", rx_ptr, rb);
      chk("R5 no read", rd_cnt, 0);
      chk("R5 no done", init_done, 0);
      stop_all();
    end

    // R2/R3/R4/R5/R6 fetch sweep
    for (int ie = 0; ie < 2; ie++)
      for (int l = 0; l < 3; l++)
        for (int tog = 0; tog < 2; tog++) begin
          lat = l;
          for (int k = 0; k < 12; k++) blk[k] = 16'h5A00 ^ 16'(k * 16'h0111 + l * 7 + ie * 3);
          blk[0] = 16'h0000;
          blk[3] = 16'h0006; blk[6] = 16'h0009;
          cur_base = {8'(8'h20 + l), 16'(16'h0100 * (ie + 1) + tog * 16'h40)};
          blk_addr_hi = cur_base[23:16]; blk_addr_lo = cur_base[15:0];
          int_en = 1'(ie);
          dwrite(1, 16'hFFFF);  // overwritten by fetch (R6)
          rd_cnt = 0; addr_err = 0;
          if (tog == 1) begin
            cmd_init = 1; cmd_start = 1; tick(); cmd_init = 0; cmd_start = 0;
          end else begin
            pulse(cmd_init);
            repeat (2) tick();
            pulse(cmd_start);
          end
          chk("R5 off during fetch", tx_on, 0);
          while (rd_cnt < 3) tick();
          dwrite(0, 16'h0003);  // ignored: mode already fetched (R6)
          for (int t = 0; t < 400 && !init_done; t++) tick();
          chk("R2 read count", rd_cnt, 12);
          chk("R2 addresses", addr_err, 0);
          chk("R3 mode", mode, blk[0]);
          chk("R6 overwrite tx lo", tx_base, {blk[2][7:0], blk[1]});
          chk("R3 tx_len", tx_len, blk[3][7:0]);
          chk("R3 rx_base", rx_base, {blk[5][7:0], blk[4]});
          chk("R3 rx_len", rx_len, blk[6][7:0]);
          chk("R4 done", init_done, 1);
          chk("R4 irq", irq, 32'(ie));
          chk("R5 tx_on after fetch", tx_on, 1);
          chk("R5 rx_on after fetch", rx_on, 1);
          chk("R9 rx_ptr after fetch", rx_ptr, {blk[5][7:0], blk[4]});
          pulse(cmd_done_clr);
          chk("R4 done cleared", init_done, 0);
          chk("R4 irq cleared", irq, 0);
          stop_all();
        end
    lat = 0;

    // R9 ring wrap over several lengths, and restart reload
    for (int len = 0; len < 5; len++) begin
      int eff;
      eff = (len == 0) ? 1 : len;
      load_direct(16'h0000, 24'h004000, 8'(len), 24'h008000, 8'd3);
      pulse(cmd_start);
      for (int k = 1; k <= 2 * eff + 1; k++) begin
        pulse(tx_adv);
        chk("R9 tx wrap", tx_ptr, 24'h004000 + 24'(8 * (k % eff)));
      end
      chk("R9 rx untouched", rx_ptr, 24'h008000);
      pulse(rx_adv);
      chk("R9 rx step", rx_ptr, 24'h008008);
      stop_all();
      dwrite(0, 16'h0000);
      pulse(cmd_start);
      chk("R9 restart tx", tx_ptr, 24'h004000);
      chk("R9 restart rx", rx_ptr, 24'h008000);
      stop_all();
    end

    // R8 errors
    load_direct(16'h0000, 24'h010000, 8'd4, 24'h020000, 8'd4);
    pulse(cmd_start);
    pulse(tx_err);
    chk("R8 tx off", tx_on, 0); chk("R8 rx stays", rx_on, 1);
    pulse(tx_adv);
    chk("R9 adv ignored off", tx_ptr, 24'h010000);
    repeat (3) tick();
    chk("R8 tx stays off", tx_on, 0);
    pulse(rx_err);
    chk("R8 rx off", rx_on, 0);
    pulse(cmd_start);
    chk("R8 tx back", tx_on, 1); chk("R8 rx back", rx_on, 1);

    // R10/R11 suspend ordering and resume
    pulse(tx_adv); pulse(tx_adv); pulse(rx_adv);
    spnd_req = 1'b1;
    tick();
    chk("R10 tx drain first", tx_drain_req, 1);
    chk("R10 rx waits", rx_drain_req, 0);
    repeat (3) tick();
    chk("R10 no status yet", spnd_stat, 0);
    pulse(tx_drain_ack);
    chk("R10 rx drain", rx_drain_req, 1);
    chk("R10 tx drain done", tx_drain_req, 0);
    chk("R10 still no status", spnd_stat, 0);
    pulse(rx_drain_ack);
    chk("R10 status", spnd_stat, 1);
    spnd_req = 1'b0;
    tick();
    chk("R11 resumed", spnd_stat, 0);
    chk("R11 tx_ptr kept", tx_ptr, 24'h010010);
    chk("R11 rx_ptr kept", rx_ptr, 24'h020008);
    chk("R11 tx_on kept", tx_on, 1);
    stop_all();

    // R10 skip drained-off section, then R12 stop while suspended
    load_direct(16'h0001, 24'h010000, 8'd4, 24'h020000, 8'd4);
    pulse(cmd_start);
    spnd_req = 1'b1;
    tick();
    chk("R10 tx skipped", tx_drain_req, 0);
    chk("R10 rx drain", rx_drain_req, 1);
    pulse(rx_drain_ack);
    chk("R10 status", spnd_stat, 1);
    pulse(cmd_stop);
    chk("R12 suspend cleared", spnd_stat, 0);
    chk("R12 rx off", rx_on, 0);
    spnd_req = 1'b0;
    tick();

    // R12 stop during fetch
    lat = 2;
    cur_base = 24'h300000; blk_addr_hi = 8'h30; blk_addr_lo = 16'h0000;
    int_en = 1'b1; rd_cnt = 0;
    cmd_init = 1; cmd_start = 1; tick(); cmd_init = 0; cmd_start = 0;
    while (rd_cnt < 3) tick();
    pulse(cmd_stop);
    chk("R12 fetch aborted", fetch_busy, 0);
    chk("R12 no request", rd_req_valid, 0);
    repeat (30) tick();
    chk("R12 no done", init_done, 0);
    chk("R12 no irq", irq, 0);
    chk("R12 tx off", tx_on, 0);
    chk("R12 reads stopped", rd_cnt, 3);

    report();
  end
endmodule